// File: doc/BRIEF.md
# Write Response Generator

This block sits on the subordinate side of a memory-mapped write port. It accepts write addresses, each tagged with a transaction ID and an exclusive-access flag, and stores them in a small queue. It then accepts write data beats while at least one address is waiting. When the beat marked last is transferred, the oldest address is retired and one response for it is queued. The block presents that response with a valid/ready handshake.

Data beats are taken in address order, and no interleaving is supported. The response carries the ID of the address it completes. Its code is EXOKAY only for an exclusive write whose reservation is still held when the last beat is transferred. Every other write gets OKAY. A separate response queue lets further data bursts complete while the response consumer stalls, until that queue is full. The reservation is a single input flag from outside logic.

Top module: `wrsp_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `b_valid` and `w_ready` are low and `aw_ready` is high.
- R2: Once `b_valid` is high, it stays high in every following cycle until a cycle in which `b_ready` is also high.
- R3: `b_id` and `b_resp` keep their values from one cycle to the next while `b_valid` is high and `b_ready` is low.
- R4: Each accepted address produces exactly one response, and only after a data beat with `w_last` high has been transferred for it. Responses come out in address acceptance order, carrying the accepted `aw_id`.
- R5: `b_resp` is 2'b01 (EXOKAY) when the address had `aw_excl` high and `resv_ok` was high in the cycle its last beat was transferred. Otherwise it is 2'b00 (OKAY). The code 2'b10 is never produced.
- R6: `aw_ready` is high exactly when fewer than AQ_DEPTH (default 4) addresses are waiting for their last data beat.
- R7: `w_ready` is high exactly when at least one address is waiting and fewer than RQ_DEPTH (default 2) responses are queued.
- R8: A response is presented on `b_valid` in the cycle after its last beat is transferred, if the queue ahead of it is empty. After a handshake (`b_valid` and `b_ready` high at a rising edge), the next queued response is presented in the following cycle.
- R9: `b_valid` is never unknown outside reset, and `b_id` and `b_resp` are never unknown while `b_valid` is high.
- R10: Once addresses stop and all their bursts and responses complete, no address remains waiting: `b_valid` is low and `aw_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted this cycle if valid |
| aw_id | input | ID_W | Transaction ID of the address |
| aw_excl | input | 1 | Address is an exclusive access |
| w_valid | input | 1 | Write data beat valid |
| w_ready | output | 1 | Data beat accepted this cycle if valid |
| w_last | input | 1 | Beat is the last of its burst |
| resv_ok | input | 1 | Exclusive reservation still held |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Response consumer ready |
| b_id | output | ID_W | ID of the completed write |
| b_resp | output | 2 | Response code (00 OKAY, 01 EXOKAY) |

## Verification
A wrong pointer or count in the address queue shows at the ports within one cycle. `aw_ready` or `w_ready` switch at the wrong fill level. Some later response then carries the wrong ID or exclusive flag, or a response goes missing or is doubled. A fault in the response queue shows as `b_valid` dropping early or staying high too long, or as `b_id`/`b_resp` changing during a stall. The bench compares all these outputs every cycle against a queue model, so a divergence is seen in the first cycle it reaches a port. The final drain then shows any address left without its response.

// File: rtl/wrsp_pkg.sv
package wrsp_pkg;
    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    function automatic logic [1:0] resp_code(input logic excl, input logic resv);
        return (excl && resv) ? RESP_EXOKAY : RESP_OKAY;
    endfunction
endpackage

// File: rtl/wrsp_fifo.sv
module wrsp_fifo #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    assign head  = st_q.mem[st_q.rd_ptr];
    assign full  = (st_q.count == FULL_CNT);
    assign empty = (st_q.count == '0);

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr_ptr] = push_data;
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6 R7: the queue is never written when full nor read when empty
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wrsp_gen.sv
module wrsp_gen
    import wrsp_pkg::*;
#(
    parameter int ID_W     = 4,
    parameter int AQ_DEPTH = 4,
    parameter int RQ_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            aw_valid,
    output logic            aw_ready,
    input  logic [ID_W-1:0] aw_id,
    input  logic            aw_excl,
    input  logic            w_valid,
    output logic            w_ready,
    input  logic            w_last,
    input  logic            resv_ok,
    output logic            b_valid,
    input  logic            b_ready,
    output logic [ID_W-1:0] b_id,
    output logic [1:0]      b_resp
);
    localparam int AQ_W = ID_W + 1;
    localparam int RQ_W = ID_W + 2;

    logic            aq_full, aq_empty, rq_full, rq_empty;
    logic [AQ_W-1:0] aq_head;
    logic [RQ_W-1:0] rq_head, rq_in;
    logic            aw_fire, w_fire, burst_done, b_fire;

    assign aw_ready   = !aq_full;
    assign aw_fire    = aw_valid && aw_ready;
    assign w_ready    = !aq_empty && !rq_full;
    assign w_fire     = w_valid && w_ready;
    assign burst_done = w_fire && w_last;
    assign b_valid    = !rq_empty;
    assign b_fire     = b_valid && b_ready;
    assign rq_in      = {aq_head[AQ_W-1:1], resp_code(aq_head[0], resv_ok)};
    assign b_id       = rq_head[RQ_W-1:2];
    assign b_resp     = rq_head[1:0];

    wrsp_fifo #(.WIDTH(AQ_W), .DEPTH(AQ_DEPTH)) i_addr_q (
        .clk(clk), .rst_n(rst_n), .push(aw_fire), .push_data({aw_id, aw_excl}),
        .pop(burst_done), .head(aq_head), .full(aq_full), .empty(aq_empty));

    wrsp_fifo #(.WIDTH(RQ_W), .DEPTH(RQ_DEPTH)) i_resp_q (
        .clk(clk), .rst_n(rst_n), .push(burst_done), .push_data(rq_in),
        .pop(b_fire), .head(rq_head), .full(rq_full), .empty(rq_empty));

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst_n;

    // R1: response valid low in the first cycle out of reset
    always_ff @(posedge clk) begin
        if (rst_n && !rst_seen_q) begin
            a_r1_bvalid_low_at_release: assert (!b_valid);
        end
    end
    // R2
    a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> b_valid);
    // R3
    a_r3_bfields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> ($stable(b_id) && $stable(b_resp)));
    // R5
    a_r5_no_slverr: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_resp != RESP_SLVERR));
    // R7: data only while an address waits
    a_r7_data_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        w_fire |-> !aq_empty);
    // R9
    a_r9_no_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(b_valid) && (!b_valid || !$isunknown({b_id, b_resp})));
endmodule

// File: tb/test_wrsp_gen.sv
module test_wrsp_gen;
    localparam int ID_W = 4;
    localparam int AQ_DEPTH = 4;
    localparam int RQ_DEPTH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aw_valid = 0, aw_excl = 0, w_valid = 0, w_last = 0, resv_ok = 0, b_ready = 0;
    logic [ID_W-1:0] aw_id = '0;
    logic aw_ready, w_ready, b_valid;
    logic [ID_W-1:0] b_id;
    logic [1:0] b_resp;

    always #5 clk = ~clk;

    wrsp_gen #(.ID_W(ID_W), .AQ_DEPTH(AQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)) i_wrsp_gen (
        .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_id(aw_id), .aw_excl(aw_excl), .w_valid(w_valid), .w_ready(w_ready),
        .w_last(w_last), .resv_ok(resv_ok), .b_valid(b_valid), .b_ready(b_ready),
        .b_id(b_id), .b_resp(b_resp));

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [ID_W:0]   aq[$];   // {id, excl}
    logic [ID_W+1:0] rq[$];   // {id, resp}

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic excl, input logic resv);
        return (excl && resv) ? 2'b01 : 2'b00;
    endfunction

    function automatic bit pct(input int p);
        return ($urandom_range(99) < p);
    endfunction

    task automatic check_outputs();
        bit ev;
        ev = (rq.size() > 0);
        chk(aw_ready == (aq.size() < AQ_DEPTH), "R6", "aw_ready", aw_ready, aq.size() < AQ_DEPTH);
        chk(w_ready == (aq.size() > 0 && rq.size() < RQ_DEPTH), "R7", "w_ready", w_ready,
            aq.size() > 0 && rq.size() < RQ_DEPTH);
        chk(b_valid === ev, "R8", "b_valid", b_valid, ev);
        if (ev) begin
            chk(!$isunknown({b_id, b_resp}), "R9", "b fields known", 0, 0);
            chk(b_id == rq[0][ID_W+1:2], "R4", "b_id", b_id, rq[0][ID_W+1:2]);
            chk(b_resp == rq[0][1:0], "R5", "b_resp", b_resp, rq[0][1:0]);
        end
    endtask

    initial begin
        bit pv, pr;
        logic [ID_W-1:0] pid;
        logic [1:0] presp;
        int pa, pw, pb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(b_valid == 1'b0, "R1", "b_valid in reset", b_valid, 0);
        chk(w_ready == 1'b0, "R1", "w_ready in reset", w_ready, 0);
        chk(aw_ready == 1'b1, "R1", "aw_ready in reset", aw_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(b_valid == 1'b0, "R1", "b_valid after release", b_valid, 0);
        chk(w_ready == 1'b0, "R1", "w_ready after release", w_ready, 0);
        pv = 0; pr = 0; pid = '0; presp = '0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (cyc > 0) @(negedge clk);
            check_outputs();
            if (pv && !pr) begin
                chk(b_valid == 1'b1, "R2", "b_valid held", b_valid, 1);
                chk(b_id == pid && b_resp == presp, "R3", "b fields held",
                    {b_id, b_resp}, {pid, presp});
            end
            if (cyc < 400)       begin pa = 50; pw = 50; pb = 50; end
            else if (cyc < 700)  begin pa = 90; pw = 5;  pb = 60; end
            else if (cyc < 1000) begin pa = 40; pw = 90; pb = 3;  end
            else if (cyc < 2700) begin pa = 35; pw = 70; pb = 70; end
            else                 begin pa = 0;  pw = 100; pb = 100; end
            aw_valid = pct(pa);
            aw_id    = ID_W'($urandom);
            aw_excl  = pct(40);
            w_valid  = pct(pw);
            w_last   = (cyc >= 2700) ? 1'b1 : pct(40);
            resv_ok  = pct(60);
            b_ready  = pct(pb);
            pv = b_valid; pr = b_ready; pid = b_id; presp = b_resp;
            // model update at the next rising edge
            if (b_valid && b_ready && rq.size() > 0) void'(rq.pop_front());
            if (w_valid && w_ready && w_last && aq.size() > 0) begin
                rq.push_back({aq[0][ID_W:1], exp_code(aq[0][0], resv_ok)});
                void'(aq.pop_front());
            end
            if (aw_valid && aw_ready) aq.push_back({aw_id, aw_excl});
        end
        @(negedge clk);
        check_outputs();
        // R10: drained, nothing outstanding
        chk(aq.size() == 0 && rq.size() == 0, "R10", "model drained", aq.size() + rq.size(), 0);
        chk(b_valid == 1'b0, "R10", "b_valid idle", b_valid, 0);
        chk(aw_ready == 1'b1, "R10", "aw_ready idle", aw_ready, 1);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule